// File: doc/BRIEF.md
# Per-Thread Interrupt Priority Window

This block is the register window that one hardware thread uses to manage interrupt priority. The core reaches it through a simple memory-mapped request port carrying an address, a write flag, a size code for 1, 2, 4 or 8 bytes, and write data. Each request is answered one cycle later with read data, an error flag and an unimplemented flag. The window is split into four 16-byte rings, one per privilege level. Only the operating-system ring at offsets 0x10..0x1F is backed by state. The other rings answer as unimplemented.

Inside the operating-system ring the thread can read its interrupt state and set its current priority threshold. It sees a pending-priority bitmap that an event input fills, the most favoured pending priority, and an exception status byte. When the most favoured pending priority is numerically below the threshold, the interrupt line to the core is raised. The thread then takes the interrupt with a 2-byte read at the acknowledge offset 0x810. That read returns the status and the new threshold, and in the same cycle it moves the threshold to the taken priority and retires that priority from the bitmap.

Multi-byte data is big-endian and right-justified. The byte at the lowest offset lands in the most significant byte of the accessed width, and bits above that width read as zero.

Top module: `thread_irq_window`

## Requirements
- R1: After reset every stored byte of the operating-system ring reads as zero, except the derived pending-priority byte at +7, which reads 0xFF while nothing is pending. The interrupt output is low.
- R2: The threshold byte is at ring offset +1 (address 0x11). A byte store to it loads values 0..7 unchanged. Any value above 7 loads 0xFF instead, and the threshold never holds a value in 8..0xFE.
- R3: A byte store to any other byte of the operating-system ring changes nothing and reports no error.
- R4: An aligned 4- or 8-byte store in the operating-system ring updates only the threshold. Its byte is taken from the lane matching address 0x11 in big-endian order, with the same clamp as R2. Every other byte is kept.
- R5: A 2-byte store in the operating-system ring, or a misaligned 4- or 8-byte store there, sets the error flag and changes no state.
- R6: Reads in the operating-system ring of size code 0/1/2/3 (1/2/4/8 bytes) that are aligned to their size return the bytes big-endian and right-justified. A misaligned read returns all ones with the error flag set.
- R7: An event with priority p (0 most favoured, 7 least) sets bit 7-p of the pending bitmap at +2. Byte +7 reads the most favoured pending priority, or 0xFF when the bitmap is empty.
- R8: The interrupt output and bit 7 of the status byte at +0 are 1 exactly when the most favoured pending priority is numerically below the threshold.
- R9: A 2-byte read at 0x810 returns {status, threshold after the read} in bits 15:0. If an interrupt was signalled, that read also sets the threshold to the pending priority, clears that priority's bitmap bit, and drops the status bit. Otherwise it changes nothing.
- R10: Any other access at or above 0x800 sets the error flag and changes no state. Such a read returns all ones.
- R11: An access below 0x800 outside 0x10..0x1F sets the unimplemented flag but not the error flag, and changes no state. Such a read returns all ones.
- R12: Every request is answered by a response strobe exactly one cycle later, and no strobe appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 12 | Byte offset into the window |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Store data, right-justified big-endian |
| evt_valid | input | 1 | Event arrival strobe |
| evt_prio | input | 3 | Priority of the arriving event |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 64 | Load data, right-justified big-endian |
| rsp_err | output | 1 | Access rejected |
| rsp_unimp | output | 1 | Access hit an unimplemented ring |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
The checker assumes that a request is held for exactly one cycle and that the size code always names one of the four legal widths. It also assumes that an event arriving in the same cycle as an acknowledge may legitimately keep the line up, so the acknowledge property is conditioned on no event in that cycle. The directed stimulus drives every request as a one-cycle pulse set up on the falling edge, and it never overlaps an event with an acknowledge. It keeps all addresses inside the 12-bit window. The clamp, the lane choice and the acknowledge side effects are read back through ordinary loads rather than observed inside the block.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 64;
    localparam int LANES       = DATA_W / 8;
    localparam int RING_BYTES  = 16;
    localparam int PRIO_LEVELS = 8;
    localparam int PRIO_W      = $clog2(PRIO_LEVELS);
    localparam logic [7:0] MAX_PRIO = 8'(PRIO_LEVELS - 1);
    localparam logic [7:0] PRIO_NONE = 8'hFF;

    // byte positions inside the operating-system ring
    localparam int POS_STAT  = 0;
    localparam int POS_THR   = 1;
    localparam int POS_PEND  = 2;
    localparam int POS_BEST  = 7;

    localparam logic [ADDR_W-1:0] OS_RING_BASE = 12'h010;
    localparam logic [ADDR_W-1:0] SPECIAL_BASE = 12'h800;
    localparam logic [ADDR_W-1:0] TAKE_ADDR    = 12'h810;

    typedef enum logic [1:0] {
        ACC_OS_RING,
        ACC_TAKE,
        ACC_SPECIAL_BAD,
        ACC_UNIMP
    } acc_kind_e;

    typedef struct packed {
        logic [7:0] thr;
        logic [7:0] pend;
    } prio_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              unimp;
    } rsp_t;

    typedef struct packed {
        prio_state_t st;
        rsp_t        rsp;
    } win_reg_t;

    function automatic logic [7:0] thr_clamp(input logic [7:0] v);
        return (v > MAX_PRIO) ? PRIO_NONE : v;
    endfunction

endpackage

// File: rtl/tirq_decode.sv
module tirq_decode
    import tirq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [1:0]        size,
    output acc_kind_e         kind,
    output logic              aligned
);
    logic [2:0] low_mask;

    always_comb begin
        low_mask = (3'b001 << size) - 3'b001;
        aligned  = ((addr[2:0] & low_mask) == 3'b000);
        if (addr >= SPECIAL_BASE) begin
            if (!write && addr == TAKE_ADDR && size == 2'd1)
                kind = ACC_TAKE;
            else
                kind = ACC_SPECIAL_BAD;
        end else if (addr[ADDR_W-1:4] == OS_RING_BASE[ADDR_W-1:4]) begin
            kind = ACC_OS_RING;
        end else begin
            kind = ACC_UNIMP;
        end
    end
endmodule

// File: rtl/tirq_prio.sv
module tirq_prio
    import tirq_pkg::*;
(
    input  logic [PRIO_LEVELS-1:0] pend,
    output logic [7:0]             best,
    output logic                   any
);
    always_comb begin
        best = PRIO_NONE;
        any  = 1'b0;
        // priority p lives in bit (LEVELS-1-p); the last hit wins, so walk from least favoured
        for (int p = PRIO_LEVELS - 1; p >= 0; p--) begin
            if (pend[PRIO_LEVELS-1-p]) begin
                best = 8'(p);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tirq_lanes.sv
module tirq_lanes
    import tirq_pkg::*;
(
    input  logic [RING_BYTES-1:0][7:0] ring,
    input  logic [3:0]                 offset,
    input  logic [1:0]                 size,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       thr_hit,
    output logic [7:0]                 thr_val
);
    int         nbytes;
    logic [3:0] idx;

    always_comb begin
        nbytes  = 1 << size;
        rdata   = '0;
        thr_hit = 1'b0;
        thr_val = '0;
        idx     = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < nbytes) begin
                idx = offset + 4'(i);
                rdata[8*(nbytes-1-i) +: 8] = ring[idx];
                if (idx == 4'(POS_THR)) begin
                    thr_hit = 1'b1;
                    thr_val = wdata[8*(nbytes-1-i) +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/thread_irq_window.sv
module thread_irq_window
    import tirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic              evt_valid,
    input  logic [2:0]        evt_prio,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_unimp,
    output logic              irq_out
);
    win_reg_t  r_q, r_d;
    acc_kind_e kind;
    logic      aligned;
    logic [7:0] best;
    logic       any_pend;
    logic       signal_q;
    logic [7:0] stat_byte;
    logic [RING_BYTES-1:0][7:0] ring;
    logic [DATA_W-1:0] lane_rdata;
    logic       thr_hit;
    logic [7:0] thr_val;
    logic [7:0] thr_now;

    tirq_decode u_decode (
        .addr    (req_addr),
        .write   (req_write),
        .size    (req_size),
        .kind    (kind),
        .aligned (aligned)
    );

    tirq_prio u_prio (
        .pend (r_q.st.pend),
        .best (best),
        .any  (any_pend)
    );

    // the threshold is 0..7 or 0xFF, so an empty bitmap (0xFF) never signals
    assign signal_q  = any_pend && (best < r_q.st.thr);
    assign stat_byte = {signal_q, 7'b0};
    assign thr_now   = r_q.st.thr;

    always_comb begin
        ring           = '0;
        ring[POS_STAT] = stat_byte;
        ring[POS_THR]  = r_q.st.thr;
        ring[POS_PEND] = r_q.st.pend;
        ring[POS_BEST] = best;
    end

    tirq_lanes u_lanes (
        .ring    (ring),
        .offset  (req_addr[3:0]),
        .size    (req_size),
        .wdata   (req_wdata),
        .rdata   (lane_rdata),
        .thr_hit (thr_hit),
        .thr_val (thr_val)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp       = '0;
        r_d.rsp.valid = req_valid;
        if (req_valid) begin
            unique case (kind)
                ACC_OS_RING: begin
                    if (!req_write) begin
                        if (aligned) begin
                            r_d.rsp.rdata = lane_rdata;
                        end else begin
                            r_d.rsp.rdata = '1;
                            r_d.rsp.err   = 1'b1;
                        end
                    end else if (req_size == 2'd1 || !aligned) begin
                        r_d.rsp.err = 1'b1;
                    end else if (thr_hit) begin
                        r_d.st.thr = thr_clamp(thr_val);
                    end
                end
                ACC_TAKE: begin
                    if (signal_q) begin
                        r_d.st.thr = best;
                        r_d.st.pend[PRIO_LEVELS-1-int'(best[PRIO_W-1:0])] = 1'b0;
                        r_d.rsp.rdata = {48'b0, stat_byte, best};
                    end else begin
                        r_d.rsp.rdata = {48'b0, stat_byte, r_q.st.thr};
                    end
                end
                ACC_SPECIAL_BAD: begin
                    r_d.rsp.err = 1'b1;
                    if (!req_write) r_d.rsp.rdata = '1;
                end
                default: begin
                    r_d.rsp.unimp = 1'b1;
                    if (!req_write) r_d.rsp.rdata = '1;
                end
            endcase
        end
        if (evt_valid)
            r_d.st.pend[PRIO_LEVELS-1-int'(evt_prio)] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.rsp.valid;
    assign rsp_rdata = r_q.rsp.rdata;
    assign rsp_err   = r_q.rsp.err;
    assign rsp_unimp = r_q.rsp.unimp;
    assign irq_out   = signal_q;
endmodule

// File: rtl/tirq_window_chk.sv
module tirq_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [1:0]  req_size,
    input logic        evt_valid,
    input logic        rsp_valid,
    input logic [63:0] rsp_rdata,
    input logic        rsp_err,
    input logic        rsp_unimp,
    input logic        irq_out,
    input logic [7:0]  thr_now
);
    logic misaligned;
    assign misaligned = (req_addr[2:0] & ((3'b001 << req_size) - 3'b001)) != 3'b000;

    // R2
    thr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_now <= 8'd7) || (thr_now == 8'hFF));

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6
    misaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[11:4] == 8'h01 && misaligned)
        |=> (rsp_err && (&rsp_rdata)));

    // R11
    unimp_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < 12'h800 && req_addr[11:4] != 8'h01)
        |=> (rsp_unimp && !rsp_err));

    // R9
    take_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 12'h810 && req_size == 2'd1 && irq_out && !evt_valid)
        |=> (rsp_rdata[15:8] == 8'h80 && !rsp_err && !irq_out));

    // R5
    half_store_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:4] == 8'h01 && req_size == 2'd1)
        |=> (rsp_err && $stable(thr_now)));
endmodule

bind thread_irq_window tirq_window_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .evt_valid (evt_valid),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .rsp_unimp (rsp_unimp),
    .irq_out   (irq_out),
    .thr_now   (thr_now)
);

// File: tb/tb_thread_irq_window.sv
module tb_thread_irq_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_prio = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic        rsp_unimp;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] got_data;
    logic        got_err, got_unimp, got_valid;

    localparam logic [63:0] ONES = '1;

    always #4 clk = ~clk;

    thread_irq_window dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .evt_valid(evt_valid), .evt_prio(evt_prio),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rsp_unimp(rsp_unimp), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_valid = rsp_valid; got_data = rsp_rdata; got_err = rsp_err; got_unimp = rsp_unimp;
    endtask

    task automatic event_in(input logic [2:0] p);
        @(negedge clk);
        evt_valid = 1'b1; evt_prio = p;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 irq after reset", 64'(irq_out), 64'd0);
        access(1'b0, 12'h010, 2'd3, '0);
        check("R1 ring after reset", got_data, 64'h00000000_000000FF);
        check("R12 response strobe", 64'(got_valid), 64'd1);
        @(negedge clk);
        check("R12 no stray strobe", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_thr_byte;
        access(1'b1, 12'h011, 2'd0, 64'h05);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R2 load 5", got_data, 64'h05);
        access(1'b1, 12'h011, 2'd0, 64'h09);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R2 clamp 9", got_data, 64'hFF);
        access(1'b1, 12'h011, 2'd0, 64'h07);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R2 load 7", got_data, 64'h07);
        access(1'b1, 12'h012, 2'd0, 64'h55);
        check("R3 no error", 64'(got_err), 64'd0);
        access(1'b0, 12'h012, 2'd0, '0);
        check("R3 byte kept", got_data, 64'h00);
    endtask

    task automatic t_event_take;
        event_in(3'd3);
        check("R8 irq raised", 64'(irq_out), 64'd1);
        access(1'b0, 12'h010, 2'd3, '0);
        check("R7 ring with event", got_data, 64'h80071000_00000003);
        access(1'b0, 12'h810, 2'd1, '0);
        check("R9 take value", got_data, 64'h8003);
        check("R9 irq dropped", 64'(irq_out), 64'd0);
        access(1'b0, 12'h010, 2'd2, '0);
        check("R9 state after take", got_data, 64'h00030000);
        access(1'b0, 12'h810, 2'd1, '0);
        check("R9 idle take", got_data, 64'h0003);
        check("R9 idle take no error", 64'(got_err), 64'd0);
    endtask

    task automatic t_wide_store;
        access(1'b1, 12'h010, 2'd2, 64'hAA06BBCC);
        check("R4 word store ok", 64'(got_err), 64'd0);
        access(1'b0, 12'h010, 2'd2, '0);
        check("R4 word store lane", got_data, 64'h00060000);
        access(1'b1, 12'h010, 2'd3, 64'h11023344_55667788);
        access(1'b0, 12'h010, 2'd3, '0);
        check("R4 dword store lane", got_data, 64'h00020000_000000FF);
        access(1'b1, 12'h018, 2'd3, 64'hFFFFFFFF_FFFFFFFF);
        access(1'b0, 12'h018, 2'd3, '0);
        check("R4 upper half kept", got_data, 64'h0);
        access(1'b1, 12'h010, 2'd2, 64'h000C0000);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R4 wide store clamp", got_data, 64'hFF);
        access(1'b1, 12'h011, 2'd0, 64'h02);
    endtask

    task automatic t_rejects;
        access(1'b1, 12'h010, 2'd1, 64'h0005);
        check("R5 half store error", 64'(got_err), 64'd1);
        access(1'b1, 12'h012, 2'd2, 64'h00050000);
        check("R5 misaligned store error", 64'(got_err), 64'd1);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R5 threshold kept", got_data, 64'h02);
        access(1'b0, 12'h010, 2'd1, '0);
        check("R6 aligned half read", got_data, 64'h0002);
        access(1'b0, 12'h011, 2'd1, '0);
        check("R6 misaligned half data", got_data, ONES);
        check("R6 misaligned half error", 64'(got_err), 64'd1);
        access(1'b0, 12'h016, 2'd2, '0);
        check("R6 misaligned word data", got_data, ONES);
    endtask

    task automatic t_special_unimp;
        access(1'b0, 12'h800, 2'd0, '0);
        check("R10 special read data", got_data, ONES);
        check("R10 special read error", 64'(got_err), 64'd1);
        access(1'b0, 12'h810, 2'd2, '0);
        check("R10 wrong take size", got_data, ONES);
        access(1'b1, 12'h810, 2'd1, 64'h0005);
        check("R10 special write error", 64'(got_err), 64'd1);
        access(1'b0, 12'h021, 2'd0, '0);
        check("R11 other ring data", got_data, ONES);
        check("R11 unimp flag", 64'(got_unimp), 64'd1);
        check("R11 no error", 64'(got_err), 64'd0);
        access(1'b0, 12'h400, 2'd2, '0);
        check("R11 high gap unimp", 64'(got_unimp), 64'd1);
        access(1'b1, 12'h001, 2'd0, 64'h06);
        check("R11 write unimp", 64'(got_unimp), 64'd1);
        access(1'b0, 12'h011, 2'd0, '0);
        check("R11 R10 threshold kept", got_data, 64'h02);
    endtask

    task automatic t_ordering;
        access(1'b1, 12'h011, 2'd0, 64'hFF);
        event_in(3'd5);
        event_in(3'd1);
        check("R8 irq with two events", 64'(irq_out), 64'd1);
        access(1'b0, 12'h012, 2'd0, '0);
        check("R7 bitmap two events", got_data, 64'h44);
        access(1'b0, 12'h017, 2'd0, '0);
        check("R7 best is 1", got_data, 64'h01);
        access(1'b1, 12'h011, 2'd0, 64'h01);
        check("R8 equal masks", 64'(irq_out), 64'd0);
        access(1'b1, 12'h011, 2'd0, 64'h02);
        check("R8 lower threshold above", 64'(irq_out), 64'd1);
        access(1'b0, 12'h810, 2'd1, '0);
        check("R9 take favoured", got_data, 64'h8001);
        access(1'b0, 12'h016, 2'd1, '0);
        check("R7 next best", got_data, 64'h0005);
        check("R8 masked by taken", 64'(irq_out), 64'd0);
        access(1'b1, 12'h011, 2'd0, 64'h00);
        event_in(3'd0);
        check("R8 threshold zero masks all", 64'(irq_out), 64'd0);
        access(1'b0, 12'h810, 2'd1, '0);
        check("R9 masked take", got_data, 64'h0000);
        access(1'b0, 12'h012, 2'd0, '0);
        check("R9 bitmap kept", got_data, 64'h84);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_thr_byte();
        t_event_take();
        t_wide_store();
        t_rejects();
        t_special_unimp();
        t_ordering();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule